// File: doc/BRIEF.md
# Split Write-Through Cache

This block sits between a requester and a memory port. It holds two independent line arrays, one serving instruction fetches and one serving data accesses, and chooses between them on each request by a fetch flag. Read misses allocate a line by fetching the whole line from memory. Stores are always forwarded to memory. A store updates the data array only when the line is already present and the memory write has succeeded. A programmable address window marks I/O space. Accesses that fall in that window go straight to memory with their own length and leave both arrays as they were.

The requester side is valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so one request is in flight at a time. The answer comes back as a single-cycle `rsp_valid` pulse that cannot be back-pressured. The memory side is also valid/ready. Once `mem_req_valid` is raised, it and every request field stay stable until `mem_req_ready` is seen. The answer from memory is a single beat that is taken whenever `mem_rsp_ready` is high.

Line byte k travels on bits [8k+7:8k] of `mem_rsp_rdata`. Requested byte i travels on bits [8i+7:8i] of the CPU data buses.

Top module: `wt_split_cache`

## Requirements
- R1: The default geometry is 4096 bytes per array, 32-byte lines and 1 way. The set index is (addr & (size-1)) >> log2(line*ways), and the tag is addr >> log2(line). Two data addresses 4096 apart evict each other.
- R2: A fetch (req_fetch=1, read) looks up and fills only the instruction array. A load (req_fetch=0) looks up and fills only the data array. A store touches only the data array.
- R3: When (addr & IO_MASK) == IO_BASE (both 0xF0000000 by default), a read is sent to memory with its own address and length. No line is allocated, so a repeated read goes to memory again.
- R4: A read hit issues no memory request. It returns the requested bytes starting at offset addr & (line-1), with bytes at or above req_len set to zero. rsp_valid rises one cycle after acceptance.
- R5: A read miss issues one memory read with mem_req_len = line size at the line-aligned address. The response carries the requested bytes from the fetched line, and later reads of that line hit.
- R6: Every valid store is sent to memory with its own address, length and data. If memory answers OK and the data array holds the line, byte i of the store replaces line byte offset+i.
- R7: A store that misses allocates nothing, so a following load of that line misses.
- R8: An error from memory during a fill is returned with rsp_err=1, and the target way is left invalid.
- R9: A memory write error is returned with rsp_err=1, and the data array is left unchanged.
- R10: A request with req_len=0, req_len > CPU bytes, or offset+len > line size is answered with rsp_err=1 and sends nothing to memory.
- R11: req_ready is low while a memory transaction is open. mem_req_valid and its fields hold until mem_req_ready. Every accepted request produces either a response or a memory request in the next cycle.
- R12: After reset, req_ready=1, rsp_valid=0, mem_req_valid=0 and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_write | input | 1 | 1 = store |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | LEN_W | Byte count, 1..CPU_B |
| req_wdata | input | CPU_B*8 | Store data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | CPU_B*8 | Read bytes, zero above req_len |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Memory byte address |
| mem_req_len | output | MLEN_W | Byte count of the transfer |
| mem_req_wdata | output | CPU_B*8 | Write data |
| mem_rsp_valid | input | 1 | Memory answer present |
| mem_rsp_ready | output | 1 | Block waits for a memory answer |
| mem_rsp_err | input | 1 | Memory answer is an error |
| mem_rsp_rdata | input | LINE_B*8 | Read bytes, byte 0 lowest |

## Verification
The main function is driven with cold loads, hits at different offsets and lengths, fetches to a line the data array already holds, and a second address 4096 bytes away. Together these separate a missing split between the arrays from a wrong set index or tag, and a wrong offset from a wrong byte mask. A store that hits and is then read back tells an offset+i update apart from a shifted one. A store that misses and is then loaded, together with repeated I/O reads, shows that neither allocates. Memory error answers on fills and on writes, and requests that cross a line or carry illegal lengths, probe the error paths. All of this runs with a memory that varies its acceptance delay.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_MREQ, ST_MWAIT} wtc_state_e;
  typedef enum logic [1:0] {K_FILL, K_IORD, K_STORE} wtc_kind_e;
endpackage

// File: rtl/wtc_route.sv
module wtc_route #(
  parameter int ADDR_W = 32,
  parameter int SIZE_B = 4096,
  parameter int LINE_B = 32,
  parameter int WAYS = 1,
  parameter int CPU_B = 4,
  parameter logic [ADDR_W-1:0] IO_MASK = 32'hF000_0000,
  parameter logic [ADDR_W-1:0] IO_BASE = 32'hF000_0000,
  localparam int OFF_W = $clog2(LINE_B),
  localparam int SETS = SIZE_B / (LINE_B * WAYS),
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int IDX_SH = $clog2(LINE_B * WAYS),
  localparam int TAG_W = ADDR_W - OFF_W,
  localparam int LEN_W = $clog2(CPU_B + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic [SET_W-1:0]  set_idx,
  output logic [TAG_W-1:0]  tag,
  output logic [OFF_W-1:0]  off,
  output logic              is_io,
  output logic              bad
);
  logic [ADDR_W-1:0] masked;
  always_comb begin
    masked  = addr & ADDR_W'(SIZE_B - 1);
    set_idx = SET_W'(masked >> IDX_SH);
    tag     = addr[ADDR_W-1:OFF_W];
    off     = addr[OFF_W-1:0];
    is_io   = (addr & IO_MASK) == IO_BASE;
    bad     = (int'(len) == 0) || (int'(len) > CPU_B) ||
              (int'(off) + int'(len) > LINE_B);
  end
endmodule

// File: rtl/wtc_array.sv
module wtc_array #(
  parameter int SETS = 128,
  parameter int WAYS = 1,
  parameter int LINE_B = 32,
  parameter int CPU_B = 4,
  parameter int TAG_W = 27,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int OFF_W = $clog2(LINE_B),
  localparam int LEN_W = $clog2(CPU_B + 1),
  localparam int LINE_W = LINE_B * 8,
  localparam int CPU_W = CPU_B * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  lk_set,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              hit,
  output logic [WAY_W-1:0]  hit_way,
  output logic [LINE_W-1:0] hit_line,
  output logic [WAY_W-1:0]  victim,
  input  logic              fill_en,
  input  logic              fill_ok,
  input  logic [SET_W-1:0]  fill_set,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              st_en,
  input  logic [SET_W-1:0]  st_set,
  input  logic [WAY_W-1:0]  st_way,
  input  logic [OFF_W-1:0]  st_off,
  input  logic [LEN_W-1:0]  st_len,
  input  logic [CPU_W-1:0]  st_wdata
);
  logic              vld   [SETS][WAYS];
  logic [TAG_W-1:0]  tags  [SETS][WAYS];
  logic [LINE_W-1:0] lines [SETS][WAYS];

  // parallel compare across the ways of the indexed set
  always_comb begin
    hit      = 1'b0;
    hit_way  = '0;
    hit_line = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld[lk_set][w] && tags[lk_set][w] == lk_tag) begin
        hit      = 1'b1;
        hit_way  = WAY_W'(w);
        hit_line = lines[lk_set][w];
      end
    end
  end

  generate
    if (WAYS > 1) begin : g_rr
      logic [WAY_W-1:0] rr [SETS];
      assign victim = rr[lk_set];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int s = 0; s < SETS; s++) rr[s] <= '0;
        end else if (fill_en && fill_ok) begin
          rr[fill_set] <= (int'(fill_way) == WAYS - 1) ? '0 : fill_way + 1'b1;
        end
      end
    end else begin : g_dm
      assign victim = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) vld[s][w] <= 1'b0;
    end else if (fill_en) begin
      vld[fill_set][fill_way] <= fill_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && fill_ok) begin
      tags[fill_set][fill_way]  <= fill_tag;
      lines[fill_set][fill_way] <= fill_line;
    end else if (st_en) begin
      for (int i = 0; i < CPU_B; i++) begin
        if (i < int'(st_len) && int'(st_off) + i < LINE_B)
          lines[st_set][st_way][(int'(st_off) + i) * 8 +: 8] <= st_wdata[i * 8 +: 8];
      end
    end
  end
endmodule

// File: rtl/wt_split_cache.sv
module wt_split_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_B = 4096,
  parameter int LINE_B = 32,
  parameter int WAYS = 1,
  parameter int CPU_B = 4,
  parameter logic [ADDR_W-1:0] IO_MASK = 32'hF000_0000,
  parameter logic [ADDR_W-1:0] IO_BASE = 32'hF000_0000,
  localparam int OFF_W = $clog2(LINE_B),
  localparam int SETS = SIZE_B / (LINE_B * WAYS),
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W = ADDR_W - OFF_W,
  localparam int LEN_W = $clog2(CPU_B + 1),
  localparam int MLEN_W = $clog2(LINE_B + 1),
  localparam int LINE_W = LINE_B * 8,
  localparam int CPU_W = CPU_B * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_fetch,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [CPU_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [CPU_W-1:0]  rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [MLEN_W-1:0] mem_req_len,
  output logic [CPU_W-1:0]  mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic              mem_rsp_err,
  input  logic [LINE_W-1:0] mem_rsp_rdata
);
  wtc_state_e        st;
  wtc_kind_e         kind;
  logic [ADDR_W-1:0] q_addr;
  logic [LEN_W-1:0]  q_len;
  logic [CPU_W-1:0]  q_wdata;
  logic [SET_W-1:0]  q_set;
  logic [TAG_W-1:0]  q_tag;
  logic [OFF_W-1:0]  q_off;
  logic [WAY_W-1:0]  q_way;
  logic              q_arr;

  logic [ADDR_W-1:0] lk_addr;
  logic [LEN_W-1:0]  lk_len;
  logic [SET_W-1:0]  r_set;
  logic [TAG_W-1:0]  r_tag;
  logic [OFF_W-1:0]  r_off;
  logic              r_io, r_bad;
  logic              sel;

  // while idle the live request is decoded, afterwards the captured one
  assign lk_addr = (st == ST_IDLE) ? req_addr : q_addr;
  assign lk_len  = (st == ST_IDLE) ? req_len  : q_len;
  assign sel     = req_write || !req_fetch;

  wtc_route #(.ADDR_W(ADDR_W), .SIZE_B(SIZE_B), .LINE_B(LINE_B), .WAYS(WAYS),
              .CPU_B(CPU_B), .IO_MASK(IO_MASK), .IO_BASE(IO_BASE)) u_route (
    .addr(lk_addr), .len(lk_len), .set_idx(r_set), .tag(r_tag), .off(r_off),
    .is_io(r_io), .bad(r_bad));

  logic [1:0]        a_hit;
  logic [WAY_W-1:0]  a_hway [2];
  logic [LINE_W-1:0] a_line [2];
  logic [WAY_W-1:0]  a_vict [2];
  logic              done, fill_go, st_go;

  assign done    = (st == ST_MWAIT) && mem_rsp_valid;
  assign fill_go = done && (kind == K_FILL);
  assign st_go   = done && (kind == K_STORE) && !mem_rsp_err && !r_io && a_hit[1];

  // index 0 serves instruction fetches, index 1 data accesses
  generate
    for (genvar g = 0; g < 2; g++) begin : g_arr
      wtc_array #(.SETS(SETS), .WAYS(WAYS), .LINE_B(LINE_B), .CPU_B(CPU_B),
                  .TAG_W(TAG_W)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .lk_set(r_set), .lk_tag(r_tag),
        .hit(a_hit[g]), .hit_way(a_hway[g]), .hit_line(a_line[g]), .victim(a_vict[g]),
        .fill_en(fill_go && (q_arr == 1'(g))), .fill_ok(!mem_rsp_err),
        .fill_set(q_set), .fill_way(q_way), .fill_tag(q_tag), .fill_line(mem_rsp_rdata),
        .st_en(st_go && (g == 1)), .st_set(r_set), .st_way(a_hway[g]),
        .st_off(r_off), .st_len(q_len), .st_wdata(q_wdata));
    end
  endgenerate

  function automatic logic [CPU_W-1:0] pick(input logic [LINE_W-1:0] ln,
                                            input logic [OFF_W-1:0] off,
                                            input logic [LEN_W-1:0] len);
    logic [LINE_W-1:0] sh;
    logic [CPU_W-1:0]  r;
    sh = ln >> (int'(off) * 8);
    r  = sh[CPU_W-1:0];
    for (int i = 0; i < CPU_B; i++)
      if (i >= int'(len)) r[i * 8 +: 8] = 8'h00;
    return r;
  endfunction

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_MREQ);
  assign mem_rsp_ready = (st == ST_MWAIT);
  assign mem_req_write = (kind == K_STORE);
  assign mem_req_addr  = (kind == K_FILL) ? {q_tag, {OFF_W{1'b0}}} : q_addr;
  assign mem_req_len   = (kind == K_FILL) ? MLEN_W'(LINE_B) : MLEN_W'(q_len);
  assign mem_req_wdata = q_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      kind      <= K_FILL;
      q_addr    <= '0;
      q_len     <= '0;
      q_wdata   <= '0;
      q_set     <= '0;
      q_tag     <= '0;
      q_off     <= '0;
      q_way     <= '0;
      q_arr     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            q_addr  <= req_addr;
            q_len   <= req_len;
            q_wdata <= req_wdata;
            q_set   <= r_set;
            q_tag   <= r_tag;
            q_off   <= r_off;
            q_arr   <= sel;
            if (r_bad) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_rdata <= '0;
            end else if (req_write) begin
              kind <= K_STORE;
              st   <= ST_MREQ;
            end else if (r_io) begin
              kind <= K_IORD;
              st   <= ST_MREQ;
            end else if (a_hit[sel]) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b0;
              rsp_rdata <= pick(a_line[sel], r_off, req_len);
            end else begin
              kind  <= K_FILL;
              q_way <= a_vict[sel];
              st    <= ST_MREQ;
            end
          end
        end
        ST_MREQ: if (mem_req_ready) st <= ST_MWAIT;
        ST_MWAIT: begin
          if (mem_rsp_valid) begin
            rsp_valid <= 1'b1;
            rsp_err   <= mem_rsp_err;
            if (mem_rsp_err || kind == K_STORE) rsp_rdata <= '0;
            else if (kind == K_FILL) rsp_rdata <= pick(mem_rsp_rdata, q_off, q_len);
            else rsp_rdata <= pick(mem_rsp_rdata, '0, q_len);
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int ADDR_W = 32,
  parameter int LINE_B = 32,
  parameter int CPU_B = 4,
  parameter logic [ADDR_W-1:0] IO_MASK = 32'hF000_0000,
  parameter logic [ADDR_W-1:0] IO_BASE = 32'hF000_0000,
  localparam int OFF_W = $clog2(LINE_B),
  localparam int LEN_W = $clog2(CPU_B + 1),
  localparam int MLEN_W = $clog2(LINE_B + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [MLEN_W-1:0] mem_req_len
);
  logic req_bad, mem_io;
  assign req_bad = (int'(req_len) == 0) || (int'(req_len) > CPU_B) ||
                   (int'(req_addr[OFF_W-1:0]) + int'(req_len) > LINE_B);
  assign mem_io  = (mem_req_addr & IO_MASK) == IO_BASE;

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_len) && $stable(mem_req_write));

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  p_progress_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid || mem_req_valid);

  p_fill_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_write && !mem_io |->
      int'(mem_req_len) == LINE_B && mem_req_addr[OFF_W-1:0] == '0);

  p_io_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_io |-> int'(mem_req_len) >= 1 && int'(mem_req_len) <= CPU_B);

  p_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_bad |=> rsp_valid && rsp_err && !mem_req_valid);
endmodule

bind wt_split_cache wtc_checker #(.ADDR_W(ADDR_W), .LINE_B(LINE_B), .CPU_B(CPU_B),
  .IO_MASK(IO_MASK), .IO_BASE(IO_BASE)) u_wtc_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_len(req_len), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len));

// File: tb/wt_split_cache_bench.sv
`timescale 1ns/1ps
module wt_split_cache_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 1'b0, req_fetch = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [2:0] req_len = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic mem_req_valid, mem_req_write, mem_rsp_ready;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [5:0] mem_req_len;
  logic [255:0] mem_rsp_rdata = '0;

  wt_split_cache u_wt_split_cache (.*);

  int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0, n_mreq = 0;
  bit finished = 0, err_fill = 0, err_wr = 0;
  logic [31:0] l_addr, l_wdata;
  logic [5:0] l_len;
  logic [7:0] wmem [logic [31:0]];

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    if (wmem.exists(a)) return wmem[a];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [31:0] a, input int len);
    logic [31:0] r = '0;
    for (int i = 0; i < len; i++) r[i * 8 +: 8] = mbyte(a + 32'(i));
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: varying acceptance delay, single-beat answer
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req_valid) begin
        repeat (n_mreq % 3) @(negedge clk);
        n_mreq++;
        l_addr = mem_req_addr; l_len = mem_req_len; l_wdata = mem_req_wdata;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        @(negedge clk);
        mem_rsp_rdata = '0;
        if (mem_req_write) begin
          n_wr++;
          mem_rsp_err = err_wr;
          if (!err_wr)
            for (int i = 0; i < int'(l_len); i++) wmem[l_addr + 32'(i)] = l_wdata[i * 8 +: 8];
        end else begin
          n_rd++;
          mem_rsp_err = err_fill;
          for (int i = 0; i < int'(l_len); i++) mem_rsp_rdata[i * 8 +: 8] = mbyte(l_addr + 32'(i));
        end
        mem_rsp_valid = 1'b1;
      end
    end
  end

  logic a_err;
  logic [31:0] a_data;
  int a_lat;
  bit a_rdy_bad;

  task automatic acc(input logic f, input logic w, input logic [31:0] a,
                     input logic [2:0] len, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_fetch = f; req_write = w; req_addr = a; req_len = len; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    a_lat = 1; a_rdy_bad = 0;
    while (!rsp_valid) begin
      if (req_ready) a_rdy_bad = 1;
      @(negedge clk);
      a_lat++;
    end
    a_err = rsp_err; a_data = rsp_rdata;
  endtask

  typedef struct packed {
    logic f; logic w; logic [31:0] a; logic [2:0] len; logic [31:0] wd;
    logic drd; logic dwr; logic err; logic [3:0] rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 32'h0000_0100, 3'd4, 32'h0, 1'b1, 1'b0, 1'b0, 4'd5},   // R5 cold miss (R12)
    '{1'b0, 1'b0, 32'h0000_0104, 3'd2, 32'h0, 1'b0, 1'b0, 1'b0, 4'd4},   // R4 hit, masked
    '{1'b1, 1'b0, 32'h0000_0100, 3'd4, 32'h0, 1'b1, 1'b0, 1'b0, 4'd2},   // R2 separate I array
    '{1'b1, 1'b0, 32'h0000_011C, 3'd4, 32'h0, 1'b0, 1'b0, 1'b0, 4'd4},   // R4 hit at line end
    '{1'b0, 1'b0, 32'h0000_1100, 3'd4, 32'h0, 1'b1, 1'b0, 1'b0, 4'd1},   // R1 same set
    '{1'b0, 1'b0, 32'h0000_0101, 3'd3, 32'h0, 1'b1, 1'b0, 1'b0, 4'd1},   // R1 evicted
    '{1'b1, 1'b0, 32'h0000_0104, 3'd4, 32'h0, 1'b0, 1'b0, 1'b0, 4'd2},   // R2 I kept
    '{1'b0, 1'b1, 32'h0000_010A, 3'd2, 32'hBEEF, 1'b0, 1'b1, 1'b0, 4'd6}, // R6 store hit
    '{1'b0, 1'b0, 32'h0000_0108, 3'd4, 32'h0, 1'b0, 1'b0, 1'b0, 4'd6},   // R6 readback
    '{1'b0, 1'b1, 32'h0000_2000, 3'd4, 32'h1234_5678, 1'b0, 1'b1, 1'b0, 4'd7}, // R7
    '{1'b0, 1'b0, 32'h0000_2000, 3'd4, 32'h0, 1'b1, 1'b0, 1'b0, 4'd7},   // R7 no alloc
    '{1'b0, 1'b0, 32'hF000_0010, 3'd2, 32'h0, 1'b1, 1'b0, 1'b0, 4'd3},   // R3 io
    '{1'b0, 1'b0, 32'hF000_0010, 3'd2, 32'h0, 1'b1, 1'b0, 1'b0, 4'd3},   // R3 io again
    '{1'b1, 1'b0, 32'h0000_011E, 3'd4, 32'h0, 1'b0, 1'b0, 1'b1, 4'd10},  // R10 crossing
    '{1'b0, 1'b0, 32'h0000_0100, 3'd0, 32'h0, 1'b0, 1'b0, 1'b1, 4'd10},  // R10 zero length
    '{1'b0, 1'b1, 32'h0000_01FE, 3'd4, 32'h1, 1'b0, 1'b0, 1'b1, 4'd10}   // R10 store crossing
  };

  initial begin
    int rd0, wr0;
    string tg;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 req_ready", 64'(req_ready), 64'd1);
    chk("R12 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R12 mem_req_valid", 64'(mem_req_valid), 64'd0);

    for (int k = 0; k < NV; k++) begin
      tg = $sformatf("R%0d row%0d", VEC[k].rq, k);
      rd0 = n_rd; wr0 = n_wr;
      acc(VEC[k].f, VEC[k].w, VEC[k].a, VEC[k].len, VEC[k].wd);
      chk({tg, " err"}, 64'(a_err), 64'(VEC[k].err));
      chk({tg, " mem reads"}, 64'(n_rd - rd0), 64'(VEC[k].drd));
      chk({tg, " mem writes"}, 64'(n_wr - wr0), 64'(VEC[k].dwr));
      if (!VEC[k].err && !VEC[k].w)
        chk({tg, " data"}, 64'(a_data), 64'(exp_rd(VEC[k].a, int'(VEC[k].len))));
      if (!VEC[k].err && !VEC[k].w && VEC[k].drd) begin
        if (VEC[k].a[31:28] == 4'hF)
          chk({tg, " io addr/len"}, {l_addr, 26'(0), l_len}, {VEC[k].a, 26'(0), 6'(VEC[k].len)});
        else
          chk({tg, " fill addr/len"}, {l_addr, 26'(0), l_len}, {VEC[k].a & ~32'h1F, 26'(0), 6'd32});
      end
      if (VEC[k].w && !VEC[k].err)
        chk({tg, " write fwd"}, {l_addr, l_wdata}, {VEC[k].a, VEC[k].wd});
      if (VEC[k].drd || VEC[k].dwr)
        chk({tg, " R11 ready low while busy"}, 64'(a_rdy_bad), 64'd0);
    end

    // R4 latency of a hit
    rd0 = n_rd;
    acc(1'b0, 1'b0, 32'h0000_0108, 3'd1, 32'h0);
    chk("R4 hit latency", 64'(a_lat), 64'd1);
    chk("R4 no mem read", 64'(n_rd - rd0), 64'd0);

    // R8 fill error leaves line invalid
    err_fill = 1;
    acc(1'b0, 1'b0, 32'h0000_3000, 3'd4, 32'h0);
    err_fill = 0;
    chk("R8 fill err", 64'(a_err), 64'd1);
    rd0 = n_rd;
    acc(1'b0, 1'b0, 32'h0000_3000, 3'd4, 32'h0);
    chk("R8 refetch", 64'(n_rd - rd0), 64'd1);
    chk("R8 data", 64'(a_data), 64'(exp_rd(32'h3000, 4)));

    // R9 write error leaves array as it was
    acc(1'b0, 1'b0, 32'h0000_0400, 3'd4, 32'h0);
    err_wr = 1;
    acc(1'b0, 1'b1, 32'h0000_0400, 3'd4, 32'hDEAD_BEEF);
    err_wr = 0;
    chk("R9 write err", 64'(a_err), 64'd1);
    rd0 = n_rd;
    acc(1'b0, 1'b0, 32'h0000_0400, 3'd4, 32'h0);
    chk("R9 still hit", 64'(n_rd - rd0), 64'd0);
    chk("R9 old data", 64'(a_data), 64'(exp_rd(32'h400, 4)));

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule